// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor that gives each procedure call its own window of registers. There are 520 physical registers. Eight are globals that every window sees. The other 512 form 32 windows. Each window shows 24 registers to the program, in three groups of eight: incoming arguments, locals and outgoing arguments. The outgoing group of a window is the same storage as the incoming group of the window that a call enters. Arguments therefore pass between caller and callee without any copy.

A 5-bit architectural register number is mapped to a physical register through the current window pointer, which is circular. There are two combinational read ports and one synchronous write port. A save request moves the pointer down by one window and a restore request moves it up by one. A 32-bit mask marks the windows that may not be entered. A rotation whose target window is masked is refused, and the block raises a one-cycle overflow flag (for a save) or underflow flag (for a restore). Any spill or refill of windows is left to the surrounding logic, which watches these flags and reloads the mask.

Top module: `rwin_regfile`

## Requirements
- R1: After synchronous reset the window pointer is 0, the mask is all zeros, both flags are low, and every register reads as zero.
- R2: Register number 0 always reads as zero, and a write to it leaves every register unchanged.
- R3: Register numbers 1 to 7 address the same seven globals whatever the window pointer holds.
- R4: In window w, numbers 8–15 select the outgoing group, 16–23 the locals and 24–31 the incoming group. The locals and incoming registers of one window are never shared with any other window.
- R5: Outgoing register 8+i of window w is the same storage as incoming register 24+i of window (w−1) mod 32.
- R6: An accepted save sets the pointer to (w−1) mod 32, so 0 goes to 31. An accepted restore sets it to (w+1) mod 32, so 31 goes to 0. With neither request the pointer holds its value.
- R7: A save whose target window has its mask bit set leaves the pointer unchanged. The overflow output is then high for exactly the following cycle.
- R8: A restore whose target window has its mask bit set leaves the pointer unchanged. The underflow output is then high for exactly the following cycle.
- R9: When save and restore are requested in the same cycle, only the save is acted on. Overflow and underflow are never high together.
- R10: When a read port names the physical register being written in the same cycle, it returns the incoming write data.
- R11: A write that shares a cycle with a rotation is mapped through the pointer value from before that rotation.
- R12: Asserting the mask load input replaces the mask at the clock edge. A rotation in the same cycle is judged against the old mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_sel | input | 5 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 5 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Register number for the write |
| wr_data | input | 32 | Write data |
| save_req | input | 1 | Rotate to the next-lower window |
| restore_req | input | 1 | Rotate to the next-higher window |
| mask_we | input | 1 | Load the invalid-window mask |
| mask_data | input | 32 | New mask value, one bit per window |
| cwp_q | output | 5 | Current window pointer |
| mask_q | output | 32 | Current invalid-window mask |
| overflow | output | 1 | Save refused because of the mask |
| underflow | output | 1 | Restore refused because of the mask |

## Verification
The bench goes after the wrap of the pointer in both directions. A design with a plain subtractor that is not wrapped would leave window 0 for a window that does not exist. It also goes after the overlap of outgoing and incoming groups: if the overlap were off by one window, a callee would read another call's arguments after a save. Refused rotations are driven with mask bits on the exact target window. A design that checked the current window, or the new mask, would either move the pointer or miss the flag. Same-cycle cases are included too: a write together with a save, a read of the register being written, a mask load together with a save, and a save together with a restore. A design that ordered any of these wrongly would store into the wrong window or return stale data.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int unsigned DEF_WIN_N  = 32;
    localparam int unsigned DEF_GRP_N  = 8;
    localparam int unsigned DEF_DATA_W = 32;

    // Register group selected by the two top bits of an architectural number
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_group_e;

    typedef enum logic [1:0] {
        ROT_IDLE    = 2'd0,
        ROT_SAVE    = 2'd1,
        ROT_RESTORE = 2'd2
    } rot_cmd_e;

    // Globals plus sixteen unique registers per window
    function automatic int unsigned phys_count(int unsigned win_n, int unsigned grp_n);
        return grp_n + win_n * 2 * grp_n;
    endfunction

    function automatic int unsigned win_prev(int unsigned w, int unsigned win_n);
        return (w == 0) ? win_n - 1 : w - 1;
    endfunction

    function automatic int unsigned win_next(int unsigned w, int unsigned win_n);
        return (w == win_n - 1) ? 0 : w + 1;
    endfunction

endpackage

// File: rtl/rwin_map.sv
// Translates an architectural register number into a physical index.
module rwin_map
    import rwin_pkg::*;
#(
    parameter int unsigned WIN_N = DEF_WIN_N,
    parameter int unsigned GRP_N = DEF_GRP_N,
    localparam int unsigned IDX_W  = $clog2(GRP_N),
    localparam int unsigned SEL_W  = IDX_W + 2,
    localparam int unsigned CWP_W  = $clog2(WIN_N),
    localparam int unsigned PHYS_N = phys_count(WIN_N, GRP_N),
    localparam int unsigned PHYS_W = $clog2(PHYS_N)
) (
    input  logic [CWP_W-1:0]  cwp,
    input  logic [SEL_W-1:0]  sel,
    output logic [PHYS_W-1:0] phys
);

    localparam int unsigned BLK = 2 * GRP_N;

    reg_group_e  grp;
    logic [31:0] idx;
    logic [31:0] win;
    logic [31:0] phys_val;

    always_comb begin
        grp = reg_group_e'(sel[SEL_W-1 -: 2]);
        idx = 32'(sel[IDX_W-1:0]);
        win = 32'(cwp);
        unique case (grp)
            GRP_GLOBAL: phys_val = idx;
            GRP_OUT:    phys_val = GRP_N + BLK * win_prev(win, WIN_N) + GRP_N + idx;
            GRP_LOCAL:  phys_val = GRP_N + BLK * win + idx;
            default:    phys_val = GRP_N + BLK * win + GRP_N + idx;
        endcase
        phys = PHYS_W'(phys_val);
    end

endmodule

// File: rtl/rwin_ptr.sv
// Window pointer, invalid-window mask and refusal flags.
module rwin_ptr
    import rwin_pkg::*;
#(
    parameter int unsigned WIN_N = DEF_WIN_N,
    localparam int unsigned CWP_W = $clog2(WIN_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             save_req,
    input  logic             restore_req,
    input  logic             mask_we,
    input  logic [WIN_N-1:0] mask_data,
    output logic [CWP_W-1:0] cwp_q,
    output logic [WIN_N-1:0] mask_q,
    output logic             overflow,
    output logic             underflow
);

    rot_cmd_e         cmd;
    logic [CWP_W-1:0] target;
    logic             target_bad;

    always_comb begin
        if (save_req)         cmd = ROT_SAVE;
        else if (restore_req) cmd = ROT_RESTORE;
        else                  cmd = ROT_IDLE;

        unique case (cmd)
            ROT_SAVE:    target = CWP_W'(win_prev(32'(cwp_q), WIN_N));
            ROT_RESTORE: target = CWP_W'(win_next(32'(cwp_q), WIN_N));
            default:     target = cwp_q;
        endcase

        target_bad = (cmd != ROT_IDLE) && mask_q[target];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q     <= '0;
            mask_q    <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            overflow  <= target_bad && (cmd == ROT_SAVE);
            underflow <= target_bad && (cmd == ROT_RESTORE);
            if (!target_bad) cwp_q <= target;
            if (mask_we)     mask_q <= mask_data;
        end
    end

endmodule

// File: rtl/rwin_store.sv
// Physical register storage with write-first read ports; entry 0 is hardwired zero.
module rwin_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PHYS_N = 520,
    parameter int unsigned RD_N   = 2,
    localparam int unsigned PHYS_W = $clog2(PHYS_N)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [PHYS_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [RD_N-1:0][PHYS_W-1:0]  rd_addr,
    output logic [RD_N-1:0][DATA_W-1:0]  rd_data
);

    logic [DATA_W-1:0] cells [PHYS_N];
    logic              wr_live;

    assign wr_live = wr_en && (wr_addr != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(PHYS_N); i++) cells[i] <= '0;
        end else if (wr_live) begin
            cells[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < int'(RD_N); p++) begin : g_rd
        assign rd_data[p] = (rd_addr[p] == '0)                  ? '0      :
                            (wr_live && wr_addr == rd_addr[p])  ? wr_data :
                                                                  cells[rd_addr[p]];
    end

endmodule

// File: rtl/rwin_regfile.sv
// Top: windowed register file with two read ports and one write port.
module rwin_regfile
    import rwin_pkg::*;
#(
    parameter int unsigned WIN_N  = DEF_WIN_N,
    parameter int unsigned GRP_N  = DEF_GRP_N,
    parameter int unsigned DATA_W = DEF_DATA_W,
    localparam int unsigned SEL_W = $clog2(GRP_N) + 2,
    localparam int unsigned CWP_W = $clog2(WIN_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  rd_a_sel,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              save_req,
    input  logic              restore_req,
    input  logic              mask_we,
    input  logic [WIN_N-1:0]  mask_data,
    output logic [CWP_W-1:0]  cwp_q,
    output logic [WIN_N-1:0]  mask_q,
    output logic              overflow,
    output logic              underflow
);

    localparam int unsigned PHYS_N = phys_count(WIN_N, GRP_N);
    localparam int unsigned PHYS_W = $clog2(PHYS_N);
    localparam int unsigned PORT_N = 3;   // index 0 write, 1 read A, 2 read B

    logic [PORT_N-1:0][SEL_W-1:0]  sel_v;
    logic [PORT_N-1:0][PHYS_W-1:0] phys_v;
    logic [1:0][DATA_W-1:0]        rd_v;

    assign sel_v = {rd_b_sel, rd_a_sel, wr_sel};

    rwin_ptr #(.WIN_N(WIN_N)) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .save_req    (save_req),
        .restore_req (restore_req),
        .mask_we     (mask_we),
        .mask_data   (mask_data),
        .cwp_q       (cwp_q),
        .mask_q      (mask_q),
        .overflow    (overflow),
        .underflow   (underflow)
    );

    for (genvar p = 0; p < int'(PORT_N); p++) begin : g_map
        rwin_map #(.WIN_N(WIN_N), .GRP_N(GRP_N)) u_map (
            .cwp  (cwp_q),
            .sel  (sel_v[p]),
            .phys (phys_v[p])
        );
    end

    rwin_store #(.DATA_W(DATA_W), .PHYS_N(PHYS_N), .RD_N(2)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (phys_v[0]),
        .wr_data (wr_data),
        .rd_addr (phys_v[2:1]),
        .rd_data (rd_v)
    );

    assign rd_a_data = rd_v[0];
    assign rd_b_data = rd_v[1];

endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
    parameter int unsigned WIN_N  = 32,
    parameter int unsigned GRP_N  = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SEL_W = $clog2(GRP_N) + 2,
    localparam int unsigned CWP_W = $clog2(WIN_N)
) (
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  rd_a_sel,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [SEL_W-1:0]  rd_b_sel,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              save_req,
    input logic              restore_req,
    input logic              mask_we,
    input logic [WIN_N-1:0]  mask_data,
    input logic [CWP_W-1:0]  cwp_q,
    input logic [WIN_N-1:0]  mask_q,
    input logic              overflow,
    input logic              underflow
);

    logic [CWP_W-1:0] dn_w;
    logic [CWP_W-1:0] up_w;

    always_comb begin
        dn_w = (cwp_q == '0) ? CWP_W'(WIN_N - 1) : cwp_q - 1'b1;
        up_w = (cwp_q == CWP_W'(WIN_N - 1)) ? '0 : cwp_q + 1'b1;
    end

    // R6
    save_step_chk: assert property (@(posedge clk) disable iff (rst)
        (save_req && !mask_q[dn_w]) |=> (cwp_q == $past(dn_w)));

    // R6
    restore_step_chk: assert property (@(posedge clk) disable iff (rst)
        (restore_req && !save_req && !mask_q[up_w]) |=> (cwp_q == $past(up_w)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!save_req && !restore_req) |=> $stable(cwp_q));

    // R7
    save_block_chk: assert property (@(posedge clk) disable iff (rst)
        (save_req && mask_q[dn_w]) |=> (overflow && $stable(cwp_q)));

    // R7
    overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |-> $past(save_req));

    // R8
    restore_block_chk: assert property (@(posedge clk) disable iff (rst)
        (restore_req && !save_req && mask_q[up_w]) |=> (underflow && $stable(cwp_q)));

    // R9
    no_dual_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !(overflow && underflow));

    // R2
    zero_a_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_sel == '0) |-> (rd_a_data == '0));

    // R2
    zero_b_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_b_sel == '0) |-> (rd_b_data == '0));

    // R10
    bypass_a_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel != '0 && wr_sel == rd_a_sel) |-> (rd_a_data == wr_data));

    // R10
    bypass_b_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel != '0 && wr_sel == rd_b_sel) |-> (rd_b_data == wr_data));

    // R12
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask_q == $past(mask_data)));

endmodule

bind rwin_regfile rwin_regfile_chk #(.WIN_N(WIN_N), .GRP_N(GRP_N), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_a_sel    (rd_a_sel),
    .rd_a_data   (rd_a_data),
    .rd_b_sel    (rd_b_sel),
    .rd_b_data   (rd_b_data),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .save_req    (save_req),
    .restore_req (restore_req),
    .mask_we     (mask_we),
    .mask_data   (mask_data),
    .cwp_q       (cwp_q),
    .mask_q      (mask_q),
    .overflow    (overflow),
    .underflow   (underflow)
);

// File: tb/rwin_regfile_test.sv
`timescale 1ns/1ps
module rwin_regfile_test;

    localparam int WN = 32;
    localparam int GN = 8;
    localparam int DW = 32;
    localparam int PN = GN + WN * 2 * GN;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0, mask_we = 1'b0;
    logic [WN-1:0] mask_data = '0, mask_q;
    logic [4:0]    cwp_q;
    logic          overflow, underflow;

    always #2.5 clk = ~clk;

    rwin_regfile uut (
        .clk(clk), .rst(rst),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .mask_we(mask_we), .mask_data(mask_data),
        .cwp_q(cwp_q), .mask_q(mask_q),
        .overflow(overflow), .underflow(underflow)
    );

    // Behavioural reference state
    logic [DW-1:0] m_mem [PN];
    int            m_cwp;
    logic [WN-1:0] m_mask;
    bit            m_ovf, m_unf;
    int            total = 0, bad = 0;

    // Physical slot per R3/R4/R5: window w owns locals then ins; outs are ins of w-1
    function automatic int slot(int w, int s);
        if (s < GN)     return s;
        if (s < 2 * GN) return GN + 2 * GN * ((w + WN - 1) % WN) + GN + (s - GN);
        if (s < 3 * GN) return GN + 2 * GN * w + (s - 2 * GN);
        return GN + 2 * GN * w + GN + (s - 3 * GN);
    endfunction

    function automatic logic [DW-1:0] expect_rd(int s);
        if (s == 0) return '0;
        if (wr_en && wr_sel != 0 && slot(m_cwp, int'(wr_sel)) == slot(m_cwp, s)) return wr_data;
        return m_mem[slot(m_cwp, s)];
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge: drive, check reads, clock, update model, check state
    task automatic cycle(string tag, bit we, int ws, logic [DW-1:0] wd, int ra, int rb,
                         bit sv, bit rs, bit mwe, logic [WN-1:0] md);
        int t;
        wr_en = we; wr_sel = 5'(ws); wr_data = wd;
        rd_a_sel = 5'(ra); rd_b_sel = 5'(rb);
        save_req = sv; restore_req = rs; mask_we = mwe; mask_data = md;
        #1;
        check(tag, "rd_a_data", 64'(rd_a_data), 64'(expect_rd(ra)));
        check(tag, "rd_b_data", 64'(rd_b_data), 64'(expect_rd(rb)));
        @(posedge clk);
        if (we && ws != 0) m_mem[slot(m_cwp, ws)] = wd;
        m_ovf = 0; m_unf = 0;
        if (sv) begin
            t = (m_cwp + WN - 1) % WN;
            if (m_mask[t]) m_ovf = 1; else m_cwp = t;
        end else if (rs) begin
            t = (m_cwp + 1) % WN;
            if (m_mask[t]) m_unf = 1; else m_cwp = t;
        end
        if (mwe) m_mask = md;
        @(negedge clk);
        check(tag, "cwp_q", 64'(cwp_q), 64'(m_cwp));
        check(tag, "mask_q", 64'(mask_q), 64'(m_mask));
        check(tag, "overflow", 64'(overflow), 64'(m_ovf));
        check(tag, "underflow", 64'(underflow), 64'(m_unf));
    endtask

    task automatic idle(string tag, int ra, int rb);
        cycle(tag, 0, 0, '0, ra, rb, 0, 0, 0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < PN; i++) m_mem[i] = '0;
        m_cwp = 0; m_mask = '0; m_ovf = 0; m_unf = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, every visible register zero
        check("R1", "cwp_q", 64'(cwp_q), 64'd0);
        check("R1", "mask_q", 64'(mask_q), 64'd0);
        check("R1", "flags", 64'({overflow, underflow}), 64'd0);
        for (int s = 0; s < 32; s++) idle("R1", s, 31 - s);

        // R2: write to register 0 has no effect
        cycle("R2", 1, 0, 32'hDEAD_BEEF, 0, 5, 0, 0, 0, '0);
        idle("R2", 0, 0);
        check("R2", "rd_a_data r0", 64'(rd_a_data), 64'd0);

        // R4: fill every window with distinct values, one save per window
        for (int w = 0; w < WN; w++) begin
            for (int s = 1; s < 32; s++)
                cycle("R4", 1, s, {8'hA5, 8'(m_cwp), 8'(s), 8'(w)}, s, 32 - s, 0, 0, 0, '0);
            cycle("R4", 0, 0, '0, 8, 24, 1, 0, 0, '0);
        end
        // R4: sweep every window reading back
        for (int w = 0; w < WN; w++) begin
            for (int s = 0; s < 16; s++) idle("R4", s + 16, s);
            cycle("R4", 0, 0, '0, 3, 12, 0, 1, 0, '0);
        end

        // R5 and R3: outs before a save appear as ins after; globals unchanged
        while (m_cwp != 0) cycle("R6", 0, 0, '0, 1, 2, 0, 1, 0, '0);
        cycle("R5", 1, 8, 32'h0000_55AA, 9, 24, 0, 0, 0, '0);
        cycle("R3", 1, 3, 32'h0333_0333, 3, 3, 0, 0, 0, '0);
        cycle("R6", 0, 0, '0, 8, 16, 1, 0, 0, '0);
        check("R6", "cwp after save from 0", 64'(cwp_q), 64'd31);
        idle("R5", 24, 3);
        check("R5", "in0 of callee", 64'(rd_a_data), 64'h55AA);
        check("R3", "global 3 after save", 64'(rd_b_data), 64'h0333_0333);
        cycle("R6", 0, 0, '0, 24, 8, 0, 1, 0, '0);
        check("R6", "cwp after restore from 31", 64'(cwp_q), 64'd0);

        // R7: save into masked window 31 is refused
        cycle("R7", 0, 0, '0, 0, 0, 0, 0, 1, 32'h8000_0000);
        cycle("R7", 0, 0, '0, 8, 8, 1, 0, 0, '0);
        check("R7", "overflow", 64'(overflow), 64'd1);
        check("R7", "cwp held", 64'(cwp_q), 64'd0);
        idle("R7", 16, 24);
        check("R7", "overflow one cycle", 64'(overflow), 64'd0);

        // R8: restore into masked window 1 is refused
        cycle("R8", 0, 0, '0, 0, 0, 0, 0, 1, 32'h0000_0002);
        cycle("R8", 0, 0, '0, 24, 8, 0, 1, 0, '0);
        check("R8", "underflow", 64'(underflow), 64'd1);
        check("R8", "cwp held", 64'(cwp_q), 64'd0);
        idle("R8", 1, 2);
        check("R8", "underflow one cycle", 64'(underflow), 64'd0);

        // R9: save and restore together, save wins even with restore target masked
        cycle("R9", 0, 0, '0, 8, 24, 1, 1, 0, '0);
        check("R9", "cwp", 64'(cwp_q), 64'd31);
        check("R9", "no underflow", 64'(underflow), 64'd0);

        // R10: write-first bypass on both ports
        cycle("R10", 1, 17, 32'h1234_5678, 17, 17, 0, 0, 0, '0);
        cycle("R10", 1, 9, 32'h0BAD_F00D, 25, 9, 0, 0, 0, '0);

        // R11: a write in the same cycle as a save lands in the old window
        cycle("R11", 1, 16, 32'hC0DE_0011, 16, 0, 1, 0, 0, '0);
        idle("R11", 16, 24);
        cycle("R11", 0, 0, '0, 16, 8, 0, 1, 0, '0);
        idle("R11", 16, 0);
        check("R11", "local in old window", 64'(rd_a_data), 64'hC0DE_0011);

        // R12: mask load with save in the same cycle uses the old mask
        cycle("R12", 0, 0, '0, 0, 0, 0, 0, 1, 32'h0);
        cycle("R12", 0, 0, '0, 5, 6, 1, 0, 1, 32'hFFFF_FFFF);
        check("R12", "save taken", 64'(overflow), 64'd0);
        cycle("R12", 0, 0, '0, 5, 6, 1, 0, 0, '0);
        check("R12", "new mask blocks", 64'(overflow), 64'd1);
        cycle("R12", 0, 0, '0, 0, 0, 0, 0, 1, 32'h0);

        // R4: mixed random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            bit mw;
            mw = ($urandom % 40) == 0;
            cycle("R4", 1'($urandom), int'($urandom % 32), $urandom,
                  int'($urandom % 32), int'($urandom % 32),
                  ($urandom % 6) == 0, ($urandom % 6) == 0, mw,
                  $urandom & $urandom & $urandom);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule